// File: doc/BRIEF.md
# Serial Packet Receiver with Idle-Timeout Latch

This block takes in a slow serial stream on a shift clock and a data line. It samples both into a fast system clock domain and shifts each data bit into a 224-bit shift register, most significant bit first, on every rising edge of the shift clock. The bit that falls out of the top of the register is sent on a serial output. A second receiver in a daisy chain therefore sees the packets that were sent earlier in the stream.

No strobe pin marks the end of a stream. The block keeps the spacing, in system clocks, between the two most recent shift-clock rising edges. When the shift clock then stays still, at either level, for eight times that spacing, an internal latch pulse fires. If the six header bits at the top of the register carry the write code, the 218 payload bits below them are copied into a data latch. Three control bits are decoded from the latch.

Top module: `serial_packet_latch`

## Requirements
- R1: Each synchronized rising edge of `sck_i` shifts the synchronized `sdi_i` into bit 0 of the 224-bit register, and the older bits move one place toward bit 223. A packet therefore arrives MSB first. Between edges the register holds.
- R2: `sdo_o` is bit 223 of the shift register. After a full packet A, each further shift puts out the next bit of A, most significant first.
- R3: The latch pulse fires once the shift clock has stayed static for 8×N system clocks, where N is the number of system clocks between the last two rising edges. `latch_valid_o` rises 8×N+4 system clocks after the last `sck_i` rise at the pin, counting the synchronizer and the pipeline.
- R4: N is taken only from the last two rising edges. A slow or fast final bit sets the timeout, whatever the rate of the earlier bits.
- R5: The payload is latched only if bits [223:218] of the register equal 6'b100101. With any other header the latch and the decoded outputs keep their values and `latch_valid_o` stays low.
- R6: On a valid pulse the latch takes bits [217:0] of the register, and `latch_valid_o` is high for exactly one system clock. At no other time does the latch change.
- R7: `ext_clk_sel_o` is latch bit 216, `repeat_en_o` is latch bit 214 and `blank_o` is latch bit 213.
- R8: After reset the latch holds zero except bit 213, so `blank_o`=1 and the outputs are off. `ext_clk_sel_o`, `repeat_en_o`, `sdo_o` and `latch_valid_o` are 0.
- R9: After a pulse has fired, no further pulse fires until a new rising edge of the shift clock arrives.
- R10: The timeout works the same whether the shift clock rests high or low.
- R11: The idle counter and the captured interval saturate at their maximum and never wrap. Periods from a few system clocks up to 2^CNT_W clocks are measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Asynchronous shift clock |
| sdi_i | input | 1 | Asynchronous serial data in |
| sdo_o | output | 1 | Serial data out toward the next receiver |
| latch_valid_o | output | 1 | One-cycle strobe when new payload is latched |
| latch_data_o | output | 218 | Latched payload |
| ext_clk_sel_o | output | 1 | Decoded external-clock select bit |
| repeat_en_o | output | 1 | Decoded repeat-enable bit |
| blank_o | output | 1 | Decoded blanking bit |

## Verification
Assertions check these rules on every cycle: the shift register holds between edges, the edge strobe lasts one cycle, and the idle counter never steps backward except on an edge. They also check that the pulse never fires twice in a row, that the latch changes only with a strobe, and that the strobe follows an internal pulse. Other behaviour can only be shown by the bench's scenarios. These are the exact timeout latency for various final intervals, the header gate, the payload and field positions, the chain output during a second packet, and the absence of a second pulse during a long idle.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int PKT_W = 224;
    localparam int CMD_W = 6;
    localparam int PAY_W = PKT_W - CMD_W;
    localparam logic [CMD_W-1:0] CMD_WRITE = 6'b100101;
    localparam int FLD_EXT   = 216;
    localparam int FLD_RPT   = 214;
    localparam int FLD_BLANK = 213;

    typedef struct packed {
        logic ext_clk;
        logic repeat_en;
        logic blank;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [PAY_W-1:0] p);
        ctrl_t c;
        c.ext_clk   = p[FLD_EXT];
        c.repeat_en = p[FLD_RPT];
        c.blank     = p[FLD_BLANK];
        return c;
    endfunction

    function automatic logic [PAY_W-1:0] reset_latch();
        logic [PAY_W-1:0] v;
        v = '0;
        v[FLD_BLANK] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/spr_sync_edge.sv
module spr_sync_edge #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         rise_o
);
    logic [W-1:0] stg_q [STAGES];
    logic         prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= '0;
                    else     stg_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= '0;
                    else     stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_o[0];
    end

    assign rise_o = sync_o[0] & ~prev_q;

    assert_edge_once_R1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/spr_shift.sv
module spr_shift #(
    parameter int W = 224
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] data_o,
    output logic         sdo_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
    end

    assign data_o = sr_q;
    assign sdo_o  = sr_q[W-1];

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/spr_idle_timer.sv
module spr_idle_timer #(
    parameter int CNT_W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic fire_o
);
    localparam int TW = CNT_W + 3;

    logic [TW-1:0]    idle_q;
    logic [CNT_W-1:0] per_q;
    logic [1:0]       seen_q;
    logic             armed_q;
    logic             fire_q;
    logic [TW-1:0]    thresh_m1;
    logic [TW:0]      idle_inc;
    logic             hit;

    assign idle_inc  = {1'b0, idle_q} + 1'b1;
    assign thresh_m1 = {per_q, 3'b000} - TW'(1);
    assign hit       = armed_q && (seen_q == 2'd2) && !rise_i && (idle_q >= thresh_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q  <= '0;
            per_q   <= '0;
            seen_q  <= '0;
            armed_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= hit;
            if (rise_i) begin
                idle_q  <= '0;
                armed_q <= 1'b1;
                if (seen_q != 2'd2) seen_q <= seen_q + 1'b1;
                if (idle_inc[TW:CNT_W] != '0) per_q <= '1;
                else                         per_q <= idle_inc[CNT_W-1:0];
            end else begin
                if (!idle_inc[TW]) idle_q <= idle_inc[TW-1:0];
                if (hit) armed_q <= 1'b0;
            end
        end
    end

    assign fire_o = fire_q;

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> (idle_q >= $past(idle_q)));
    assert_single_fire_R9: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);
endmodule

// File: rtl/serial_packet_latch.sv
module serial_packet_latch
    import spr_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_i,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic             latch_valid_o,
    output logic [PAY_W-1:0] latch_data_o,
    output logic             ext_clk_sel_o,
    output logic             repeat_en_o,
    output logic             blank_o
);
    logic [1:0]       sync_w;
    logic             sck_rise;
    logic [PKT_W-1:0] sr_w;
    logic             fire_w;
    logic             cmd_ok;
    logic [PAY_W-1:0] latch_q;
    logic             valid_q;
    ctrl_t            ctrl;

    spr_sync_edge #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst(rst), .async_i({sdi_i, sck_i}),
        .sync_o(sync_w), .rise_o(sck_rise)
    );

    spr_shift #(.W(PKT_W)) u_shift (
        .clk(clk), .rst(rst), .shift_i(sck_rise), .din_i(sync_w[1]),
        .data_o(sr_w), .sdo_o(sdo_o)
    );

    spr_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .rise_i(sck_rise), .fire_o(fire_w)
    );

    assign cmd_ok = (sr_w[PKT_W-1 -: CMD_W] == CMD_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= reset_latch();
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (fire_w && cmd_ok) begin
                latch_q <= sr_w[PAY_W-1:0];
                valid_q <= 1'b1;
            end
        end
    end

    assign ctrl          = decode_ctrl(latch_q);
    assign latch_valid_o = valid_q;
    assign latch_data_o  = latch_q;
    assign ext_clk_sel_o = ctrl.ext_clk;
    assign repeat_en_o   = ctrl.repeat_en;
    assign blank_o       = ctrl.blank;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(latch_q));
    assert_strobe_once_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    assert_gate_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(fire_w));
endmodule

// File: tb/serial_packet_latch_bench.sv
`timescale 1ns/1ps
module serial_packet_latch_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, vld, ext, rpt, blk;
    logic [217:0] ldat;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int rise_cyc = 0;
    int sdo_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_packet_latch u_serial_packet_latch (
        .clk(clk), .rst(rst), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
        .latch_valid_o(vld), .latch_data_o(ldat),
        .ext_clk_sel_o(ext), .repeat_en_o(rpt), .blank_o(blk)
    );

    typedef struct packed {
        logic [5:0] cmd;
        logic       f_ext;
        logic       f_rpt;
        logic       f_blk;
        logic [7:0] hp;
        logic [7:0] last_low;
        logic       end_high;
        logic       expect_latch;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{6'h25, 1'b1, 1'b0, 1'b0, 8'd3,  8'd3,  1'b0, 1'b1},
        '{6'h25, 1'b0, 1'b1, 1'b1, 8'd5,  8'd5,  1'b1, 1'b1},
        '{6'h24, 1'b1, 1'b1, 1'b0, 8'd3,  8'd3,  1'b0, 1'b0},
        '{6'h25, 1'b1, 1'b1, 1'b0, 8'd2,  8'd20, 1'b0, 1'b1},
        '{6'h25, 1'b0, 1'b1, 1'b0, 8'd20, 8'd3,  1'b1, 1'b1},
        '{6'h3F, 1'b0, 1'b0, 1'b1, 8'd4,  8'd4,  1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [223:0] make_pkt(input logic [5:0] cmd, input logic e,
                                               input logic r, input logic b, input int seed);
        logic [223:0] p;
        for (int i = 0; i < 213; i++) p[i] = (((i * 7) + (seed * 3)) % 5) < 2;
        p[223:218] = cmd;
        p[217] = seed[0];
        p[216] = e;
        p[215] = seed[1];
        p[214] = r;
        p[213] = b;
        return p;
    endfunction

    // Sends 224 bits MSB first. The last bit's low phase is last_low, so the final
    // rise-to-rise interval is hp + last_low system clocks.
    task automatic send_pkt(input logic [223:0] p, input int hp, input int last_low,
                            input bit final_pkt, input bit end_high,
                            input bit chk_sdo, input logic [223:0] prev);
        @(negedge clk);
        sck = 1'b0;
        for (int i = 223; i >= 0; i--) begin
            int low;
            sdi = p[i];
            low = (final_pkt && i == 0) ? last_low : hp;
            repeat (low) @(negedge clk);
            if (chk_sdo && sdo !== prev[i]) sdo_bad++;
            sck = 1'b1;
            rise_cyc = cyc;
            if (!(final_pkt && i == 0 && end_high)) begin
                repeat (hp) @(negedge clk);
                sck = 1'b0;
            end
        end
    endtask

    // Waits up to limit cycles for the strobe; returns delay from the last rise or -1.
    task automatic wait_valid(input int limit, output int delay);
        delay = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (vld === 1'b1) begin
                delay = cyc - rise_cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R3: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [217:0] exp_latch;
        logic [223:0] pa, pb;
        int d, n, seen;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(blk === 1'b1, "R8", "blank after reset", blk, 1);
        check(ext === 1'b0 && rpt === 1'b0, "R8", "ext/rpt after reset", {ext, rpt}, 0);
        check(vld === 1'b0 && sdo === 1'b0, "R8", "strobe/sdo after reset", {vld, sdo}, 0);
        exp_latch = '0;
        exp_latch[213] = 1'b1;
        check(ldat === exp_latch, "R8", "latch after reset", ldat[63:0], exp_latch[63:0]);

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int t = 0; t < 6; t++) begin
            vec_t v;
            v = TBL[t];
            pa = make_pkt(v.cmd, v.f_ext, v.f_rpt, v.f_blk, t + 1);
            send_pkt(pa, v.hp, v.last_low, 1'b1, v.end_high, 1'b0, '0);
            n = int'(v.hp) + int'(v.last_low);
            wait_valid(8 * n + 20, d);
            if (v.expect_latch) begin
                exp_latch = pa[217:0];
                check(d >= 8 * n + 2 && d <= 8 * n + 6, "R3",
                      $sformatf("timeout delay vec %0d (R4 R10)", t), d, 8 * n + 4);
                @(negedge clk);
                check(vld === 1'b0, "R6", $sformatf("strobe width vec %0d", t), vld, 0);
            end else begin
                check(d == -1, "R5", $sformatf("no strobe on bad header vec %0d", t), d, -1);
            end
            check(ldat === exp_latch, "R6", $sformatf("latched payload vec %0d", t),
                  ldat[63:0], exp_latch[63:0]);
            check({ext, rpt, blk} === {exp_latch[216], exp_latch[214], exp_latch[213]}, "R7",
                  $sformatf("decoded fields vec %0d", t), {ext, rpt, blk},
                  {exp_latch[216], exp_latch[214], exp_latch[213]});
        end

        // R9: long idle after a pulse produces no second pulse
        seen = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (vld === 1'b1) seen++;
        end
        check(seen == 0, "R9", "no second pulse during long idle", seen, 0);

        // R1 R2: two packets back to back; chain output carries the first
        pa = make_pkt(6'h25, 1'b1, 1'b1, 1'b1, 9);
        pb = make_pkt(6'h25, 1'b0, 1'b0, 1'b0, 12);
        send_pkt(pa, 3, 3, 1'b0, 1'b0, 1'b0, '0);
        check(vld === 1'b0, "R3", "no latch between chained packets", vld, 0);
        sdo_bad = 0;
        send_pkt(pb, 3, 3, 1'b1, 1'b0, 1'b1, pa);
        check(sdo_bad == 0, "R2", "sdo streams first packet MSB first", sdo_bad, 0);
        wait_valid(8 * 6 + 20, d);
        check(d >= 8 * 6 + 2 && d <= 8 * 6 + 6, "R3", "timeout after chain", d, 8 * 6 + 4);
        check(ldat === pb[217:0], "R1", "register holds last packet only",
              ldat[63:0], pb[63:0]);
        @(negedge clk);
        check(sdo === pb[223], "R2", "sdo shows new top bit", sdo, pb[223]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule